// File: doc/BRIEF.md
# Serial Flash Direct-Window Access Sequencer

This block turns a single memory read or write of one to eight bytes into a complete serial flash transaction. The address space it serves is split into equal windows, and each window belongs to one chip select. When a request lands in a window, the block drives that chip select low. It sends an opcode and the address inside the window, adds dummy clocks on reads, and then moves the data bytes. At the end it raises the chip select again and completes the request. The opcode, the address length and the dummy length come from two configuration words, one for reads and one for writes. A byte-wide shifter handshake carries each serial transfer.

The requester holds its request steady with `req_valid` high. The block accepts the request in `ST_IDLE` and walks the states `ST_CMD` → `ST_ADDR` → `ST_DUMMY` → `ST_DATA` → `ST_DONE` → `ST_IDLE`. `ST_ADDR` is skipped when no address bytes are due. `ST_DUMMY` is skipped on writes and whenever the dummy count is zero. The transition out of `ST_CMD`, `ST_ADDR` and `ST_DUMMY` happens on the shifter handshake of the last byte of that phase. `ST_DATA` leaves to `ST_DONE` on the handshake of the last data byte. `ST_DONE` always returns to `ST_IDLE` after one cycle. `req_ready` is high only in `ST_DONE`, and read data is presented alongside it.

Top module: `sfd_seq`

## Requirements
- R1: While reset is held and right after it, all chip selects are high, and `req_ready`, `sh_valid`, `err_addr_size` and `err_overlap` are low.
- R2: The chip select index is the address bits above the window offset. Address bit 27 selects the chip select with the default 128 MiB windows. Only that chip select (active low) is low for every transfer of the transaction.
- R3: The first transfer is the opcode. It is bits 7:0 of `wr_cfg` for writes and of `rd_cfg` for reads.
- R4: The address length comes from bits 17:16 of the selected config word: code 0 gives 3 bytes and code 1 gives 4 bytes. Address bytes are the window offset zero-extended to 32 bits, sent most significant byte first. Any byte offset is accepted.
- R5: A read sends ((bits 13:12 × 8) >> bits 9:8) dummy transfers of `rd_cfg`. They come after the address, with `sh_dummy` high and `sh_tx` zero. A write sends none.
- R6: `req_size` encodes bytes−1, giving 1 to 8 bytes. Write bytes go out least significant first, starting from `req_wdata[7:0]`. On a read, the i-th received data byte lands in `req_rdata[8i+7:8i]`, and the bytes that were not read are zero.
- R7: `req_ready` stays low until the last data transfer has completed. It is then high for exactly one cycle, and all chip selects are high in that cycle.
- R8: Address-length codes 2 and 3 send no address bytes and set `err_addr_size`, which stays set until reset.
- R9: A change of address, direction or size on the request port while a transaction is running sets `err_overlap`, which stays set until reset. The running transaction completes with the request that was accepted.
- R10: `sh_valid` is high only while a chip select is low. While waiting for `sh_ready`, it holds `sh_tx` and the chip selects steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present; held until `req_ready` |
| req_ready | output | 1 | One-cycle completion strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 28 | Window index (top bit) and window offset |
| req_size | input | 3 | Byte count minus one |
| req_wdata | input | 64 | Write bytes, little-endian |
| req_rdata | output | 64 | Read bytes, little-endian, valid with `req_ready` |
| rd_cfg | input | 32 | Read opcode, address length, dummy fields |
| wr_cfg | input | 32 | Write opcode and address length |
| sh_valid | output | 1 | Shifter transfer request |
| sh_ready | input | 1 | Shifter completes the transfer this cycle |
| sh_dummy | output | 1 | Transfer is one dummy clock |
| sh_tx | output | 8 | Byte to shift out |
| sh_rx | input | 8 | Byte shifted in, valid with `sh_ready` |
| cs_n | output | 2 | Chip selects, active low |
| err_addr_size | output | 1 | Sticky invalid address length flag |
| err_overlap | output | 1 | Sticky request-changed-while-busy flag |

## Verification
A transfer completes on the rising edge where `sh_valid` and `sh_ready` are both high. The next transfer, or `ST_DONE`, follows one cycle later, so `req_ready`, the released chip selects and `req_rdata` are all due in the cycle after the last data handshake. The bench model of the shifter logs each byte on the falling edge where it raises `sh_ready`. The bench requester polls `req_ready` on falling edges and compares the complete log, the read data and the error flags in that cycle. It then checks on the following falling edge that `req_ready` has dropped.

// File: rtl/sfd_pkg.sv
package sfd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_ADDR,
        ST_DUMMY,
        ST_DATA,
        ST_DONE
    } seq_state_t;

    localparam int CFG_W = 32;
    localparam int CNT_W = 5;

    typedef struct packed {
        logic [7:0]       opcode;
        logic [2:0]       addr_bytes;
        logic             addr_bad;
        logic [CNT_W-1:0] dummy_n;
    } xfer_plan_t;

endpackage

// File: rtl/sfd_cfg_decode.sv
module sfd_cfg_decode
    import sfd_pkg::*;
(
    input  logic             is_write,
    input  logic [CFG_W-1:0] rd_cfg,
    input  logic [CFG_W-1:0] wr_cfg,
    output xfer_plan_t       plan
);
    logic [CFG_W-1:0] cfg;
    logic [1:0]       asz;
    logic [CNT_W-1:0] dummy_raw;

    always_comb begin
        cfg       = is_write ? wr_cfg : rd_cfg;
        asz       = cfg[17:16];
        dummy_raw = {rd_cfg[13:12], 3'b000} >> rd_cfg[9:8];
        plan.opcode = cfg[7:0];
        unique case (asz)
            2'd0: begin plan.addr_bytes = 3'd3; plan.addr_bad = 1'b0; end
            2'd1: begin plan.addr_bytes = 3'd4; plan.addr_bad = 1'b0; end
            default: begin plan.addr_bytes = 3'd0; plan.addr_bad = 1'b1; end
        endcase
        plan.dummy_n = is_write ? '0 : dummy_raw;
    end
endmodule

// File: rtl/sfd_cs_drive.sv
module sfd_cs_drive #(
    parameter int NUM_CS = 2,
    localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic              active,
    input  logic [CS_W-1:0]   sel,
    output logic [NUM_CS-1:0] cs_n
);
    for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
        assign cs_n[g] = !(active && (sel == CS_W'(g)));
    end
endmodule

// File: rtl/sfd_rd_pack.sv
module sfd_rd_pack #(
    parameter int DATA_BYTES = 8,
    localparam int IDX_W     = (DATA_BYTES > 1) ? $clog2(DATA_BYTES) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    capture,
    input  logic [IDX_W-1:0]        idx,
    input  logic [7:0]              rx,
    output logic [8*DATA_BYTES-1:0] data
);
    for (genvar g = 0; g < DATA_BYTES; g++) begin : g_byte
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                data[8*g +: 8] <= '0;
            end else if (clear) begin
                data[8*g +: 8] <= '0;
            end else if (capture && (idx == IDX_W'(g))) begin
                data[8*g +: 8] <= rx;
            end
        end
    end
endmodule

// File: rtl/sfd_seq.sv
module sfd_seq
    import sfd_pkg::*;
#(
    parameter int NUM_CS     = 2,
    parameter int WIN_BITS   = 27,
    parameter int DATA_BYTES = 8,
    localparam int CS_W      = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
    localparam int ADDR_W    = WIN_BITS + CS_W,
    localparam int SIZE_W    = (DATA_BYTES > 1) ? $clog2(DATA_BYTES) : 1,
    localparam int DATA_W    = 8 * DATA_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [SIZE_W-1:0] req_size,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] req_rdata,
    input  logic [CFG_W-1:0]  rd_cfg,
    input  logic [CFG_W-1:0]  wr_cfg,
    output logic              sh_valid,
    input  logic              sh_ready,
    output logic              sh_dummy,
    output logic [7:0]        sh_tx,
    input  logic [7:0]        sh_rx,
    output logic [NUM_CS-1:0] cs_n,
    output logic              err_addr_size,
    output logic              err_overlap
);
    seq_state_t        state, state_nxt;
    xfer_plan_t        plan_in, plan_q;
    logic [ADDR_W-1:0] lat_addr;
    logic              lat_write;
    logic [SIZE_W-1:0] lat_size;
    logic [DATA_W-1:0] lat_wdata;
    logic [CNT_W-1:0]  cnt;
    logic [31:0]       off32;
    logic              hs, accept, cs_active, req_changed;

    sfd_cfg_decode u_decode (
        .is_write (req_write),
        .rd_cfg   (rd_cfg),
        .wr_cfg   (wr_cfg),
        .plan     (plan_in)
    );

    sfd_cs_drive #(.NUM_CS(NUM_CS)) u_cs (
        .active (cs_active),
        .sel    (lat_addr[ADDR_W-1 -: CS_W]),
        .cs_n   (cs_n)
    );

    sfd_rd_pack #(.DATA_BYTES(DATA_BYTES)) u_pack (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept),
        .capture (hs && (state == ST_DATA) && !lat_write),
        .idx     (cnt[SIZE_W-1:0]),
        .rx      (sh_rx),
        .data    (req_rdata)
    );

    assign off32       = {{(32-WIN_BITS){1'b0}}, lat_addr[WIN_BITS-1:0]};
    assign hs          = sh_valid && sh_ready;
    assign accept      = (state == ST_IDLE) && req_valid;
    assign req_changed = (req_addr != lat_addr) || (req_write != lat_write)
                         || (req_size != lat_size);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // Next-state selection
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:  if (req_valid) state_nxt = ST_CMD;
            ST_CMD: begin
                if (sh_ready) begin
                    if (plan_q.addr_bytes != 3'd0)    state_nxt = ST_ADDR;
                    else if (plan_q.dummy_n != '0)    state_nxt = ST_DUMMY;
                    else                              state_nxt = ST_DATA;
                end
            end
            ST_ADDR: begin
                if (sh_ready && cnt == '0) begin
                    if (plan_q.dummy_n != '0) state_nxt = ST_DUMMY;
                    else                      state_nxt = ST_DATA;
                end
            end
            ST_DUMMY: if (sh_ready && cnt == '0) state_nxt = ST_DATA;
            ST_DATA:  if (sh_ready && cnt == CNT_W'(lat_size)) state_nxt = ST_DONE;
            ST_DONE:  state_nxt = ST_IDLE;
            default:  state_nxt = ST_IDLE;
        endcase
    end

    // Outputs decoded from the state
    always_comb begin
        sh_valid  = 1'b0;
        sh_dummy  = 1'b0;
        sh_tx     = '0;
        cs_active = 1'b0;
        req_ready = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_CMD: begin
                sh_valid  = 1'b1;
                cs_active = 1'b1;
                sh_tx     = plan_q.opcode;
            end
            ST_ADDR: begin
                sh_valid  = 1'b1;
                cs_active = 1'b1;
                sh_tx     = 8'(off32 >> (8 * cnt[1:0]));
            end
            ST_DUMMY: begin
                sh_valid  = 1'b1;
                cs_active = 1'b1;
                sh_dummy  = 1'b1;
            end
            ST_DATA: begin
                sh_valid  = 1'b1;
                cs_active = 1'b1;
                sh_tx     = lat_write ? 8'(lat_wdata >> (8 * cnt)) : 8'h00;
            end
            ST_DONE:  req_ready = 1'b1;
            default: ;
        endcase
    end

    // Request capture, phase counter and error flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            plan_q        <= '0;
            lat_addr      <= '0;
            lat_write     <= 1'b0;
            lat_size      <= '0;
            lat_wdata     <= '0;
            cnt           <= '0;
            err_addr_size <= 1'b0;
            err_overlap   <= 1'b0;
        end else begin
            if (accept) begin
                plan_q    <= plan_in;
                lat_addr  <= req_addr;
                lat_write <= req_write;
                lat_size  <= req_size;
                lat_wdata <= req_wdata;
                if (plan_in.addr_bad) err_addr_size <= 1'b1;
            end
            if (state != ST_IDLE && req_valid && req_changed) err_overlap <= 1'b1;
            if (hs) begin
                if (state_nxt != state) begin
                    unique case (state_nxt)
                        ST_ADDR:  cnt <= CNT_W'(plan_q.addr_bytes) - CNT_W'(1);
                        ST_DUMMY: cnt <= plan_q.dummy_n - CNT_W'(1);
                        default:  cnt <= '0;
                    endcase
                end else if (state == ST_DATA) begin
                    cnt <= cnt + CNT_W'(1);
                end else begin
                    cnt <= cnt - CNT_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/sfd_seq_chk.sv
module sfd_seq_chk #(
    parameter int NUM_CS = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              sh_valid,
    input logic              sh_ready,
    input logic              sh_dummy,
    input logic [7:0]        sh_tx,
    input logic [NUM_CS-1:0] cs_n,
    input logic              err_addr_size,
    input logic              err_overlap
);
    // R2: never more than one chip select low
    a_r2_single_cs: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    // R7: completion strobe lasts one cycle with every chip select released
    a_r7_ready_cs_released: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (&cs_n));
    a_r7_ready_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> !req_ready);

    // R5: a dummy transfer carries a zero byte
    a_r5_dummy_zero: assert property (@(posedge clk) disable iff (!rst_n)
        sh_dummy |-> (sh_valid && sh_tx == 8'h00));

    // R8 / R9: error flags are sticky
    a_r8_addr_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_addr_size |=> err_addr_size);
    a_r9_overlap_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_overlap |=> err_overlap);

    // R10: transfers only under a chip select, held while waiting
    a_r10_valid_under_cs: assert property (@(posedge clk) disable iff (!rst_n)
        sh_valid |-> !(&cs_n));
    a_r10_hold_while_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_valid && !sh_ready) |=> (sh_valid && $stable(sh_tx) && $stable(cs_n)
                                     && $stable(sh_dummy)));
endmodule

bind sfd_seq sfd_seq_chk #(.NUM_CS(NUM_CS)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_ready     (req_ready),
    .sh_valid      (sh_valid),
    .sh_ready      (sh_ready),
    .sh_dummy      (sh_dummy),
    .sh_tx         (sh_tx),
    .cs_n          (cs_n),
    .err_addr_size (err_addr_size),
    .err_overlap   (err_overlap)
);

// File: tb/sfd_seq_tb_top.sv
module sfd_seq_tb_top;
    localparam int NUM_CS = 2;
    localparam int WIN_BITS = 27;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [27:0] req_addr = '0;
    logic [2:0]  req_size = '0;
    logic [63:0] req_wdata = '0;
    logic [63:0] req_rdata;
    logic [31:0] rd_cfg = 32'h0000_000B;
    logic [31:0] wr_cfg = 32'h0000_0002;
    logic        sh_valid;
    logic        sh_ready = 1'b0;
    logic        sh_dummy;
    logic [7:0]  sh_tx;
    logic [7:0]  sh_rx = '0;
    logic [1:0]  cs_n;
    logic        err_addr_size;
    logic        err_overlap;

    int n_chk = 0;
    int n_fail = 0;
    bit timed_out = 0;

    logic [7:0] log_tx [0:63];
    logic       log_dm [0:63];
    logic [1:0] log_cs [0:63];
    int         log_n = 0;
    int         wait_cnt = 0;

    always #2 clk = ~clk;

    sfd_seq dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .req_rdata(req_rdata), .rd_cfg(rd_cfg), .wr_cfg(wr_cfg),
        .sh_valid(sh_valid), .sh_ready(sh_ready), .sh_dummy(sh_dummy),
        .sh_tx(sh_tx), .sh_rx(sh_rx), .cs_n(cs_n),
        .err_addr_size(err_addr_size), .err_overlap(err_overlap)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Shifter model: random wait, logs each completed transfer
    initial begin
        forever begin
            @(negedge clk);
            if (sh_ready) begin
                sh_ready = 1'b0;
            end else if (sh_valid) begin
                if (wait_cnt > 0) begin
                    wait_cnt--;
                end else if (log_n < 64) begin
                    log_tx[log_n] = sh_tx;
                    log_dm[log_n] = sh_dummy;
                    log_cs[log_n] = cs_n;
                    sh_rx    = 8'hA5 ^ 8'(log_n);
                    sh_ready = 1'b1;
                    log_n++;
                    wait_cnt = int'($urandom_range(0, 2));
                end
            end
        end
    end

    function automatic int addr_len(input logic [31:0] cfg);
        return (cfg[17:16] == 2'd0) ? 3 : (cfg[17:16] == 2'd1) ? 4 : 0;
    endfunction

    function automatic int dummy_len(input bit wr, input logic [31:0] cfg);
        if (wr) return 0;
        return (int'(cfg[13:12]) * 8) >> cfg[9:8];
    endfunction

    task automatic run_req(input bit wr, input int cs, input logic [26:0] off,
                           input int nbytes, input logic [63:0] wd,
                           input logic [31:0] rc, input logic [31:0] wc,
                           input bit glitch);
        logic [31:0] cfg;
        logic [31:0] off32;
        logic [63:0] exp_rd;
        int na, nd, base, cyc;
        @(negedge clk);
        rd_cfg = rc; wr_cfg = wc; log_n = 0;
        req_write = wr; req_addr = {cs[0], off};
        req_size = 3'(nbytes - 1); req_wdata = wd; req_valid = 1'b1;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
            if (glitch && cyc == 3) req_addr[0] = ~req_addr[0];
            if (glitch && cyc == 4) req_addr[0] = ~req_addr[0];
            if (cyc > 2000) begin
                timed_out = 1;
                chk(0, "R7 watchdog", 64'(cyc), 64'd0);
                break;
            end
        end while (!req_ready);
        if (timed_out) return;
        cfg = wr ? wc : rc;
        na = addr_len(cfg);
        nd = dummy_len(wr, rc);
        off32 = {5'd0, off};
        chk(log_n == 1 + na + nd + nbytes, "R6 transfer count", 64'(log_n),
            64'(1 + na + nd + nbytes));
        chk(log_tx[0] == cfg[7:0] && !log_dm[0], "R3 opcode", 64'(log_tx[0]),
            64'(cfg[7:0]));
        for (int i = 0; i < na; i++)
            chk(log_tx[1+i] == 8'(off32 >> (8*(na-1-i))) && !log_dm[1+i],
                "R4 address byte", 64'(log_tx[1+i]), 64'(8'(off32 >> (8*(na-1-i)))));
        for (int i = 0; i < nd; i++)
            chk(log_dm[1+na+i] && log_tx[1+na+i] == 8'h00, "R5 dummy",
                64'(log_tx[1+na+i]), 64'h0);
        base = 1 + na + nd;
        exp_rd = '0;
        for (int i = 0; i < nbytes; i++) begin
            if (wr)
                chk(log_tx[base+i] == wd[8*i +: 8] && !log_dm[base+i],
                    "R6 write byte", 64'(log_tx[base+i]), 64'(wd[8*i +: 8]));
            exp_rd[8*i +: 8] = 8'hA5 ^ 8'(base + i);
        end
        for (int i = 0; i < log_n; i++)
            chk(log_cs[i] == ~(2'b01 << cs), "R2 chip select", 64'(log_cs[i]),
                64'(~(2'b01 << cs)));
        if (!wr) chk(req_rdata == exp_rd, "R6 read data", req_rdata, exp_rd);
        chk(cs_n == 2'b11, "R7 cs released at ready", 64'(cs_n), 64'h3);
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready, "R7 ready one cycle", 64'(req_ready), 64'h0);
    endtask

    initial begin
        logic [31:0] rc, wc;
        void'($urandom(32'h5EED_0123));
        repeat (3) @(negedge clk);
        chk(cs_n == 2'b11 && !req_ready && !sh_valid, "R1 reset outputs",
            {61'd0, cs_n, req_ready}, 64'h6);
        chk(!err_addr_size && !err_overlap, "R1 reset flags",
            {62'd0, err_addr_size, err_overlap}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cs_n == 2'b11 && !sh_valid, "R1 after release", 64'(cs_n), 64'h3);

        // Random mix
        for (int t = 0; t < 60 && !timed_out; t++) begin
            rc = $urandom;
            wc = $urandom;
            rc[17:16] = 2'($urandom_range(0, 1));
            wc[17:16] = 2'($urandom_range(0, 1));
            run_req(1'($urandom_range(0, 1)), int'($urandom_range(0, 1)),
                    27'($urandom), int'($urandom_range(1, 8)),
                    {$urandom, $urandom}, rc, wc, 1'b0);
        end
        chk(!err_addr_size && !err_overlap, "R8 R9 no spurious flags",
            {62'd0, err_addr_size, err_overlap}, 64'h0);

        // Directed corners
        run_req(1'b0, 0, 27'h000_0001, 8, '0, 32'h0000_300B, 32'h2, 1'b0); // 24 dummies
        run_req(1'b0, 1, 27'h7FF_FFFF, 1, '0, 32'h0001_1303, 32'h2, 1'b0); // 1 dummy, 4-byte addr
        run_req(1'b0, 1, 27'h123_4567, 3, '0, 32'h0000_0003, 32'h2, 1'b0); // no dummies
        run_req(1'b1, 1, 27'h7FF_FFFF, 8, 64'h8877_6655_4433_2211,
                32'h0B, 32'h0001_3302, 1'b0);                             // write, 4-byte addr
        run_req(1'b1, 0, 27'h000_0000, 1, 64'hEE, 32'h0B, 32'h0000_0002, 1'b0);

        // R8: invalid address length
        chk(!err_addr_size, "R8 flag clear before", 64'(err_addr_size), 64'h0);
        run_req(1'b0, 0, 27'h0AB_CDEF, 2, '0, 32'h0002_100B, 32'h2, 1'b0);
        chk(err_addr_size, "R8 flag set", 64'(err_addr_size), 64'h1);
        run_req(1'b1, 1, 27'h000_0100, 2, 64'h5A5A, 32'h0B, 32'h0003_0002, 1'b0);
        chk(err_addr_size, "R8 flag sticky", 64'(err_addr_size), 64'h1);

        // R9: request changes mid-transaction
        chk(!err_overlap, "R9 flag clear before", 64'(err_overlap), 64'h0);
        run_req(1'b0, 1, 27'h055_5550, 4, '0, 32'h0000_100B, 32'h2, 1'b1);
        chk(err_overlap, "R9 flag set", 64'(err_overlap), 64'h1);
        run_req(1'b0, 0, 27'h000_0010, 1, '0, 32'h0000_000B, 32'h2, 1'b0);
        chk(err_overlap, "R9 flag sticky", 64'(err_overlap), 64'h1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(4 * 190000);
        n_chk++;
        n_fail++;
        $display("FAIL R7 global watchdog actual=expired expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule